// File: doc/BRIEF.md
# Clock configuration SMBus byte-access slave

This block sits on a two-wire management bus and holds the control bits of a clock generator in four byte-wide registers. Each register can be written or read one byte per transaction. A write sends the device address with the write bit, a command byte, and one data byte, with an acknowledge after each of the three. A read sends the device address with the write bit and the command byte, then a repeated start and the device address with the read bit. The slave returns one byte, and the master ends the transfer with a not-acknowledge and a stop. The command byte must carry a 1 in its top bit to mark a byte access. Its low seven bits name the register.

The registers drive the frequency-select code, the spread-spectrum mode, enable and bandwidth, four output enables, the PCI drive-strength selection and the CPU power-down behaviour. The strap inputs are latched on the first clock after reset is released. An override bit decides whether the frequency-select code comes from these latched straps or from software. Bus lines arrive already filtered and are sampled on the system clock. `sda_oe` high means the pad pulls the data line low.

The transfer controller moves through these states:
- ST_IDLE goes to ST_ADDR on a start.
- ST_ADDR goes to ST_ADDR_ACK after eight bits.
- ST_ADDR_ACK goes to ST_CMD on a matching write address, to ST_RDATA on a matching read address, and to ST_IGNORE on a mismatch.
- ST_CMD goes to ST_CMD_ACK after eight bits.
- ST_CMD_ACK goes to ST_WDATA when the top command bit is set, and to ST_IGNORE when it is clear.
- ST_WDATA goes to ST_WDATA_ACK after eight bits, and ST_WDATA_ACK then goes to ST_IGNORE.
- ST_RDATA goes to ST_RDATA_ACK after eight bits, and ST_RDATA_ACK goes to ST_IGNORE once the master's acknowledge bit has been sampled.
- A start in any state goes to ST_ADDR. A stop in any state goes to ST_IDLE.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The slave acknowledges (pulls data low in the ninth clock) only an address byte whose upper seven bits equal DEV_ADDR (default 7'h69). On any other address it never drives the line, and the rest of that transfer changes no register.
- R2: A command byte with bit 7 clear is not acknowledged, and the data byte that follows is discarded. With bit 7 set, the command is acknowledged and bits 6:0 select the register offset.
- R3: A complete byte write (address+write, command, data) is acknowledged three times. It updates the addressed register at the data byte's acknowledge, and control outputs change only then.
- R4: A byte read (address+write, command, repeated start, address+read) returns the addressed register MSB first. The slave drives the data line only while the clock is low, and releases it for the master's acknowledge bit.
- R5: Offset 0 holds the override flag in bit 3, fs_sel[2:0] in bits 6:4 and fs_sel[3] in bit 1. A write whose bit 3 is 1 sets the override and loads those four bits, and fs_sel follows them. Bits 7, 2 and 0 read 0.
- R6: While the override is 0, written frequency bits are ignored. Offset 0 bits 6:4 and 1 and fs_sel then show the frequency straps latched at reset release.
- R7: Offset 1 bit 7 reads the latched CPU-mode strap and bit 6 the latched multiplier strap; writes to these bits are discarded. Bit 5 is the power-down control. Bits 4 and 3 drive cpu_en and cpuod_en directly, with no further register stage. Bits 2:0 read 0.
- R8: Offset 2 bit 7 drives pci_f_en and bit 6 drives pci_drv_hi (1 = stronger drive). Bit 5 is reserved and reads 1. Bits 4:0 read 0.
- R9: Offset 3 bit 7 is ss_center (0 = down spread, 1 = center), bit 6 is ss_en and bits 5:4 are ss_bw. Bits 3:0 read 0.
- R10: After reset the registers read 8'h22 (with straps 4'b1010), 8'h98 (CPU-mode strap 1, multiplier strap 0), 8'hA0 and 8'h40. Strap changes after reset release have no effect.
- R11: With CPU-mode strap 1 and pd_n low, power-down control 0 asserts cpu_pd_drive and 1 asserts cpu_pd_tristate. With pd_n high, or with CPU-mode strap 0, both stay low, and they are never high together.
- R12: A stop in any state returns the slave to idle, and an unfinished write changes nothing. Offsets 4 to 127 are acknowledged, read 8'h00 and discard writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| strap_fs | input | 4 | Frequency-select straps |
| strap_cpu_mode | input | 1 | CPU interface mode strap (1 = power-down control honoured) |
| strap_mult0 | input | 1 | Multiplier strap |
| pd_n | input | 1 | Power-down request, active low |
| fs_sel | output | 4 | Effective frequency-select code |
| cpu_en | output | 1 | CPU clock pair enable |
| cpuod_en | output | 1 | Second CPU clock pair enable |
| pci_f_en | output | 1 | Free-running PCI clock enable |
| pci_drv_hi | output | 1 | PCI drive strength raised |
| ss_center | output | 1 | Spread mode, 1 = center |
| ss_en | output | 1 | Spread enable |
| ss_bw | output | 2 | Spread bandwidth select |
| cpu_pd_drive | output | 1 | Power-down: true output at reference level, complement low |
| cpu_pd_tristate | output | 1 | Power-down: both CPU outputs three-stated |

## Verification
The main function is exercised with a sequence of write-then-read pairs. The pairs cover all-zero, all-one and mixed data bytes at every mapped offset, so reserved, read-only and strap-driven bits show whether they were kept apart from writable ones. The override is set and then cleared with frequency bits still set in the data, which shows whether software values or latched straps win. The remaining patterns are a wrong address, a command with its top bit clear, a stop right after the command, and an unmapped offset. Each must leave the registers untouched, and the mismatch cases must also withhold the acknowledge. A second reset with the other CPU-mode strap shows whether the power-down outputs depend on that strap.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int OFF_W    = 7;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 4;

    localparam logic [OFF_W-1:0] OFF_FREQ   = 7'd0;
    localparam logic [OFF_W-1:0] OFF_OUTS   = 7'd1;
    localparam logic [OFF_W-1:0] OFF_PCI    = 7'd2;
    localparam logic [OFF_W-1:0] OFF_SPREAD = 7'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } xfer_state_t;
endpackage

// File: rtl/smb_line_sense.sv
module smb_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_a, scl_b, sda_a, sda_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_a <= 1'b1;
            scl_b <= 1'b1;
            sda_a <= 1'b1;
            sda_b <= 1'b1;
        end else begin
            scl_a <= scl_i;
            scl_b <= scl_a;
            sda_a <= sda_i;
            sda_b <= sda_a;
        end
    end

    always_comb begin
        scl_s     = scl_a;
        sda_s     = sda_a;
        scl_rise  = scl_a & ~scl_b;
        scl_fall  = ~scl_a & scl_b;
        // data edge while the clock stays high marks a bus condition
        start_evt = scl_a & scl_b & sda_b & ~sda_a;
        stop_evt  = scl_a & scl_b & ~sda_b & sda_a;
    end
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [DATA_W-1:0] rd_data,
    output xfer_state_t       state,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [OFF_W-1:0]  reg_off,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] byte_in;
    logic              ack_ph, ack_ok, is_read;

    assign byte_in = {shreg[DATA_W-2:0], sda_s};

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            ack_ph  <= 1'b0;
            ack_ok  <= 1'b0;
            is_read <= 1'b0;
            reg_off <= '0;
            wr_data <= '0;
            wr_stb  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (stop_evt) begin
                state  <= ST_IDLE;
                ack_ph <= 1'b0;
            end else if (start_evt) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                ack_ph <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: ;
                    ST_ADDR: if (scl_rise) begin
                        shreg <= byte_in;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            state   <= ST_ADDR_ACK;
                            ack_ok  <= (byte_in[DATA_W-1:1] == DEV_ADDR);
                            is_read <= byte_in[0];
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        ack_ph <= ~ack_ph;
                        if (ack_ph) begin
                            cnt <= '0;
                            if (!ack_ok)      state <= ST_IGNORE;
                            else if (is_read) begin
                                state <= ST_RDATA;
                                shreg <= rd_data;
                            end else          state <= ST_CMD;
                        end
                    end
                    ST_CMD: if (scl_rise) begin
                        shreg <= byte_in;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            state  <= ST_CMD_ACK;
                            ack_ok <= byte_in[DATA_W-1];
                            if (byte_in[DATA_W-1]) reg_off <= byte_in[OFF_W-1:0];
                        end
                    end
                    ST_CMD_ACK: if (scl_fall) begin
                        ack_ph <= ~ack_ph;
                        if (ack_ph) begin
                            cnt   <= '0;
                            state <= ack_ok ? ST_WDATA : ST_IGNORE;
                        end
                    end
                    ST_WDATA: if (scl_rise) begin
                        shreg <= byte_in;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            state   <= ST_WDATA_ACK;
                            ack_ok  <= 1'b1;
                            wr_data <= byte_in;
                            wr_stb  <= 1'b1;
                        end
                    end
                    ST_WDATA_ACK: if (scl_fall) begin
                        ack_ph <= ~ack_ph;
                        if (ack_ph) state <= ST_IGNORE;
                    end
                    ST_RDATA: if (scl_fall) begin
                        if (cnt == LAST_BIT) state <= ST_RDATA_ACK;
                        else begin
                            shreg <= {shreg[DATA_W-2:0], 1'b1};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                    ST_RDATA_ACK: if (scl_rise) state <= ST_IGNORE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // line driver
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = ack_ph & ack_ok;
            ST_RDATA:                              sda_oe = ~shreg[DATA_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        strap_fs,
    input  logic              strap_cpu_mode,
    input  logic              strap_mult0,
    input  logic              pd_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              cap_done,
    output logic              ovr,
    output logic [3:0]        fs_sel,
    output logic              cpu_en,
    output logic              cpuod_en,
    output logic              pci_f_en,
    output logic              pci_drv_hi,
    output logic              ss_center,
    output logic              ss_en,
    output logic [1:0]        ss_bw,
    output logic              cpu_pd_drive,
    output logic              cpu_pd_tristate
);
    logic [3:0] cap_fs, sw_fs;
    logic       cap_mode, cap_mult0, pd_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_done   <= 1'b0;
            cap_fs     <= '0;
            cap_mode   <= 1'b0;
            cap_mult0  <= 1'b0;
            ovr        <= 1'b0;
            sw_fs      <= '0;
            pd_ctrl    <= 1'b0;
            cpu_en     <= 1'b1;
            cpuod_en   <= 1'b1;
            pci_f_en   <= 1'b1;
            pci_drv_hi <= 1'b0;
            ss_center  <= 1'b0;
            ss_en      <= 1'b1;
            ss_bw      <= 2'b00;
        end else begin
            if (!cap_done) begin
                cap_done  <= 1'b1;
                cap_fs    <= strap_fs;
                cap_mode  <= strap_cpu_mode;
                cap_mult0 <= strap_mult0;
            end
            if (wr_stb) begin
                unique case (reg_off)
                    OFF_FREQ: begin
                        ovr <= wr_data[3];
                        if (wr_data[3]) sw_fs <= {wr_data[1], wr_data[6:4]};
                    end
                    OFF_OUTS: begin
                        pd_ctrl  <= wr_data[5];
                        cpu_en   <= wr_data[4];
                        cpuod_en <= wr_data[3];
                    end
                    OFF_PCI: begin
                        pci_f_en   <= wr_data[7];
                        pci_drv_hi <= wr_data[6];
                    end
                    OFF_SPREAD: begin
                        ss_center <= wr_data[7];
                        ss_en     <= wr_data[6];
                        ss_bw     <= wr_data[5:4];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        fs_sel = ovr ? sw_fs : cap_fs;
        unique case (reg_off)
            OFF_FREQ:   rd_data = {1'b0, fs_sel[2:0], ovr, 1'b0, fs_sel[3], 1'b0};
            OFF_OUTS:   rd_data = {cap_mode, cap_mult0, pd_ctrl, cpu_en, cpuod_en, 3'b000};
            OFF_PCI:    rd_data = {pci_f_en, pci_drv_hi, 1'b1, 5'b00000};
            OFF_SPREAD: rd_data = {ss_center, ss_en, ss_bw, 4'b0000};
            default:    rd_data = '0;
        endcase
        cpu_pd_drive    = cap_mode & ~pd_n & ~pd_ctrl;
        cpu_pd_tristate = cap_mode & ~pd_n & pd_ctrl;
    end
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [3:0] strap_fs,
    input  logic       strap_cpu_mode,
    input  logic       strap_mult0,
    input  logic       pd_n,
    output logic [3:0] fs_sel,
    output logic       cpu_en,
    output logic       cpuod_en,
    output logic       pci_f_en,
    output logic       pci_drv_hi,
    output logic       ss_center,
    output logic       ss_en,
    output logic [1:0] ss_bw,
    output logic       cpu_pd_drive,
    output logic       cpu_pd_tristate
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              wr_stb, cap_done, ovr;
    logic [OFF_W-1:0]  reg_off;
    logic [DATA_W-1:0] wr_data, rd_data;
    xfer_state_t       state;

    smb_line_sense u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    smb_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
        .rd_data(rd_data), .state(state), .sda_oe(sda_oe), .wr_stb(wr_stb),
        .reg_off(reg_off), .wr_data(wr_data)
    );

    cfg_regbank u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .reg_off(reg_off),
        .wr_data(wr_data), .strap_fs(strap_fs), .strap_cpu_mode(strap_cpu_mode),
        .strap_mult0(strap_mult0), .pd_n(pd_n), .rd_data(rd_data),
        .cap_done(cap_done), .ovr(ovr), .fs_sel(fs_sel), .cpu_en(cpu_en),
        .cpuod_en(cpuod_en), .pci_f_en(pci_f_en), .pci_drv_hi(pci_drv_hi),
        .ss_center(ss_center), .ss_en(ss_en), .ss_bw(ss_bw),
        .cpu_pd_drive(cpu_pd_drive), .cpu_pd_tristate(cpu_pd_tristate)
    );
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk
    import clkcfg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input xfer_state_t state,
    input logic        sda_oe,
    input logic        scl_s,
    input logic        stop_evt,
    input logic        wr_stb,
    input logic        cap_done,
    input logic        ovr,
    input logic [3:0]  fs_sel,
    input logic [7:0]  cfg_low,
    input logic        pd_n,
    input logic        cpu_pd_drive,
    input logic        cpu_pd_tristate
);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    assert_stop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE));

    assert_drive_clock_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    assert_cfg_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_low) |-> $past(wr_stb));

    assert_fs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && $past(!ovr) && $past(cap_done)) |-> $stable(fs_sel));

    assert_pd_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_pd_drive && cpu_pd_tristate));

    assert_pd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pd_n |-> (!cpu_pd_drive && !cpu_pd_tristate));
endmodule

bind clkcfg_smbus_slave clkcfg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_oe(sda_oe), .scl_s(scl_s),
    .stop_evt(stop_evt), .wr_stb(wr_stb), .cap_done(cap_done), .ovr(ovr),
    .fs_sel(fs_sel),
    .cfg_low({cpu_en, cpuod_en, pci_f_en, pci_drv_hi, ss_center, ss_en, ss_bw}),
    .pd_n(pd_n), .cpu_pd_drive(cpu_pd_drive), .cpu_pd_tristate(cpu_pd_tristate)
);

// File: tb/sim_clkcfg_smbus_slave.sv
`timescale 1ns/1ps
module sim_clkcfg_smbus_slave;
    localparam logic [6:0] ADDR = 7'h69;
    localparam int NVEC = 12;
    // {offset, write byte, expected readback, expected {fs_sel,cpu_en,cpuod_en,pci_f_en,pci_drv_hi,ss_center,ss_en,ss_bw}}
    localparam logic [34:0] VEC [NVEC] = '{
        {7'd0, 8'h78, 8'h78, 12'h7E4},
        {7'd0, 8'hFF, 8'h7A, 12'hFE4},
        {7'd0, 8'h70, 8'h22, 12'hAE4},
        {7'd1, 8'h00, 8'h80, 12'hA24},
        {7'd1, 8'hFF, 8'hB8, 12'hAE4},
        {7'd2, 8'h00, 8'h20, 12'hAC4},
        {7'd2, 8'hC0, 8'hE0, 12'hAF4},
        {7'd3, 8'hB0, 8'hB0, 12'hAFB},
        {7'd3, 8'h00, 8'h00, 12'hAF0},
        {7'd3, 8'hFF, 8'hF0, 12'hAFF},
        {7'd5, 8'hAA, 8'h00, 12'hAFF},
        {7'd3, 8'h40, 8'h40, 12'hAF4}
    };
    localparam string VTAG [NVEC] = '{"R5", "R5", "R6", "R7", "R7", "R8",
                                      "R8", "R9", "R9", "R9", "R12", "R9"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic [3:0] strap_fs = 4'b1010;
    logic strap_cpu_mode = 1'b1, strap_mult0 = 1'b0, pd_n = 1'b1;
    logic sda_oe, cpu_en, cpuod_en, pci_f_en, pci_drv_hi, ss_center, ss_en;
    logic cpu_pd_drive, cpu_pd_tristate;
    logic [3:0] fs_sel;
    logic [1:0] ss_bw;
    wire sda_line = sda_drv & ~sda_oe;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clkcfg_smbus_slave #(.DEV_ADDR(ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_fs(strap_fs), .strap_cpu_mode(strap_cpu_mode), .strap_mult0(strap_mult0),
        .pd_n(pd_n), .fs_sel(fs_sel), .cpu_en(cpu_en), .cpuod_en(cpuod_en),
        .pci_f_en(pci_f_en), .pci_drv_hi(pci_drv_hi), .ss_center(ss_center),
        .ss_en(ss_en), .ss_bw(ss_bw), .cpu_pd_drive(cpu_pd_drive),
        .cpu_pd_tristate(cpu_pd_tristate)
    );

    wire [11:0] outs = {fs_sel, cpu_en, cpuod_en, pci_f_en, pci_drv_hi, ss_center, ss_en, ss_bw};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; hw(); scl_drv = 1'b1; hw(); sda_drv = 1'b0; hw(); scl_drv = 1'b0; hw();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; hw(); scl_drv = 1'b1; hw(); sda_drv = 1'b1; hw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; hw(); scl_drv = 1'b1; hw(); scl_drv = 1'b0;
        end
        sda_drv = 1'b1; hw(); scl_drv = 1'b1; hw();
        nack = sda_line;
        scl_drv = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        sda_drv = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hw(); scl_drv = 1'b1; hw(); b = {b[6:0], sda_line}; scl_drv = 1'b0;
        end
        sda_drv = 1'b1; hw(); scl_drv = 1'b1; hw(); scl_drv = 1'b0; hw();
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] cmd,
                            input logic [7:0] d, output logic [2:0] nacks);
        bus_start();
        send_byte({a, 1'b0}, nacks[2]);
        send_byte(cmd, nacks[1]);
        send_byte(d, nacks[0]);
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] cmd,
                           output logic [7:0] d, output logic [2:0] nacks);
        bus_start();
        send_byte({a, 1'b0}, nacks[2]);
        send_byte(cmd, nacks[1]);
        bus_start();
        send_byte({a, 1'b1}, nacks[0]);
        recv_byte(d);
        bus_stop();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hw(); rst_n = 1'b1; hw();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [2:0] na;
        do_reset();
        // R10: power-up values, then strap changes after release must not show
        chk("R10 outputs after reset", 32'(outs), 32'hAE4);
        chk("R10 sda released", 32'(sda_oe), 32'h0);
        strap_fs = 4'b0101; strap_mult0 = 1'b1;
        do_read(ADDR, 8'h80, rd, na); chk("R10 reg0 default", 32'(rd), 32'h22);
        chk("R4 read acks", 32'(na), 32'h0);
        do_read(ADDR, 8'h81, rd, na); chk("R10 reg1 default", 32'(rd), 32'h98);
        do_read(ADDR, 8'h82, rd, na); chk("R10 reg2 default", 32'(rd), 32'hA0);
        do_read(ADDR, 8'h83, rd, na); chk("R10 reg3 default", 32'(rd), 32'h40);
        chk("R10 fs_sel keeps latched strap", 32'(fs_sel), 32'hA);

        for (int v = 0; v < NVEC; v++) begin
            do_write(ADDR, {1'b1, VEC[v][34:28]}, VEC[v][27:20], na);
            chk({VTAG[v], " R3 write acks"}, 32'(na), 32'h0);
            chk({VTAG[v], " outputs after write"}, 32'(outs), 32'(VEC[v][11:0]));
            do_read(ADDR, {1'b1, VEC[v][34:28]}, rd, na);
            chk({VTAG[v], " R4 readback"}, 32'(rd), 32'(VEC[v][19:12]));
        end

        // R1: wrong address is not acknowledged and writes nothing
        do_write(7'h2A, 8'h83, 8'hF0, na);
        chk("R1 address nack", 32'(na[2]), 32'h1);
        do_read(ADDR, 8'h83, rd, na); chk("R1 reg untouched", 32'(rd), 32'h40);

        // R2: command with bit 7 clear
        do_write(ADDR, 8'h03, 8'hF0, na);
        chk("R2 command nack", 32'(na[1:0]), 32'h3);
        do_read(ADDR, 8'h83, rd, na); chk("R2 reg untouched", 32'(rd), 32'h40);

        // R12: stop after command aborts the write
        bus_start(); send_byte({ADDR, 1'b0}, na[2]); send_byte(8'h83, na[1]); bus_stop();
        chk("R12 aborted write outputs", 32'(outs), 32'hAF4);
        do_read(ADDR, 8'h83, rd, na); chk("R12 read after abort", 32'(rd), 32'h40);

        // R11: power-down handling with mode strap 1
        do_write(ADDR, 8'h81, 8'h18, na);
        pd_n = 1'b0; hw();
        chk("R11 pd drive", 32'({cpu_pd_drive, cpu_pd_tristate}), 32'h2);
        do_write(ADDR, 8'h81, 8'h38, na);
        chk("R11 pd tristate", 32'({cpu_pd_drive, cpu_pd_tristate}), 32'h1);
        pd_n = 1'b1; hw();
        chk("R11 pd released", 32'({cpu_pd_drive, cpu_pd_tristate}), 32'h0);

        // R11/R7: mode strap 0 ignores power-down control
        strap_cpu_mode = 1'b0; strap_fs = 4'b1010; strap_mult0 = 1'b0;
        do_reset();
        do_write(ADDR, 8'h81, 8'h38, na);
        pd_n = 1'b0; hw();
        chk("R11 other mode ignores pd", 32'({cpu_pd_drive, cpu_pd_tristate}), 32'h0);
        do_read(ADDR, 8'h81, rd, na); chk("R7 mode strap read", 32'(rd), 32'h38);
        pd_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule